// File: doc/BRIEF.md
# SRAM March Diagnosis Engine

This block sits between a small synchronous SRAM and the logic that normally uses it. With the diagnosis select low, the SRAM ports carry the system's reads and writes unchanged. With it high, the system side is cut off and an internal engine takes the array. A start pulse makes the engine run a list of March-style test commands, taken either from a fixed set inside the engine or from a chain that was shifted in serially. For each command the engine steps through every address in the chosen direction and applies that command's write and read operations at each one.

The engine does not stop with a single pass/fail result. When a read returns a word that differs from the expected one, it stops issuing operations. It then shifts out one fixed-width record giving the physical address, the operation slot and the word it read, sets a sticky error flag, and picks up the command again at the next operation. A done output rises once the final command has finished.

Top module: `sram_diag_top`

## Requirements
- R1: With `diag_sel` low, `mem_addr`, `mem_wdata`, `mem_we` and `mem_oe` follow the matching `sys_*` inputs, and `sys_rdata` returns `mem_rdata`.
- R2: With `diag_sel` high, system accesses never reach the SRAM. When the engine is idle, `mem_we` and `mem_oe` are low and `sys_rdata` reads zero. A system write attempted in this mode leaves the stored word unchanged.
- R3: A command is 13 bits. Bits [1:0] hold the number of operations minus one (1 to 4). Bit 2 is the direction (0 up, 1 down). Bit 3 is the background (0 gives all zeros, 1 gives 0x55 repeated). Operation slot k sits at bits [5+2k:4+2k] as {invert, read}, where read=1 means read-and-compare and read=0 means write. Bit 12 marks the last command. The data for an operation is the background, XORed with all ones when invert is set.
- R4: With `cmd_src` low, the built-in set runs in this order: up {w0}; up {r0,w1}; down {r1,w0}; up {r0}, with 0 meaning the background.
- R5: With `cmd_src` high, commands come from a chain shifted one bit per cycle from `scan_in` while `scan_en` is high and the engine is not running. Slot i occupies chain bits [13i+12:13i], so the last bit shifted in becomes bit 0 of slot 0.
- R6: A start pulse while idle or done, with `diag_sel` high, clears the session, address and command counters and clears `err_flag`.
- R7: A write takes one cycle with `mem_we` high. A read takes two cycles: `mem_oe` is high for the first and the compare happens in the second. The two enables are never high together, and one extra cycle follows start. The fault-free built-in set therefore completes 145 cycles after the start edge on a 16-word array.
- R8: An up command visits addresses 0 to N-1. A down command visits N-1 down to 0.
- R9: On a mismatch the engine raises `err_sout_vld` for 14 cycles, starting the cycle after the compare. During these cycles `err_sout` gives {address[3:0], session[1:0], read data[7:0]} MSB first, and `err_flag` is set.
- R10: While a record is being shifted out, no SRAM operation is issued. Afterwards the engine resumes at the operation that follows the failing read, so every later fault in the same run is also reported.
- R11: `err_flag` stays high until the next start.
- R12: `done` goes high after the final command (bit 12 set, or the last slot) completes, and it holds until the next start or until `diag_sel` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SRAM |
| rst_n | input | 1 | Synchronous active-low reset |
| diag_sel | input | 1 | 1 hands the SRAM to the engine |
| cmd_src | input | 1 | 0 selects the built-in commands, 1 the scanned chain |
| start | input | 1 | Pulse to begin a run |
| scan_en | input | 1 | Shift enable for the command chain |
| scan_in | input | 1 | Serial command data |
| sys_addr | input | AW | System address |
| sys_wdata | input | DW | System write data |
| sys_we | input | 1 | System write enable |
| sys_oe | input | 1 | System read enable |
| sys_rdata | output | DW | Read data returned to the system |
| mem_addr | output | AW | SRAM address |
| mem_wdata | output | DW | SRAM write data |
| mem_we | output | 1 | SRAM write enable |
| mem_oe | output | 1 | SRAM read enable (data one cycle later) |
| mem_rdata | input | DW | SRAM read data |
| err_sout | output | 1 | Serial error record |
| err_sout_vld | output | 1 | High while a record bit is on err_sout |
| err_flag | output | 1 | Sticky error flag |
| done | output | 1 | Run finished |

## Verification
The embedded assertions check several properties on every cycle. The write and read enables are never high together. The system side stays blocked while diagnosis mode is selected. Counters hold still while a record is pending. A record always begins the cycle after a mismatch. The error flag falls only in the start cycle, and the continue pulse lasts a single cycle. Other behaviour only the directed scenarios can show. These include the content and order of the records, their addresses for the up and down directions, and the session index inside a three-operation command. They also cover the command encoding, the chain shifting order, the cycle count of a clean run, and what the array holds afterwards.

// File: rtl/sram_diag_pkg.sv
// Shared types for the SRAM diagnosis engine.
// Assumes at most four operations per command element.
package sram_diag_pkg;

    localparam int OPS_MAX = 4;

    // One operation slot: invert the background, and read (1) or write (0).
    typedef struct packed {
        logic inv;
        logic rd;
    } diag_op_t;

    // Command word; bit positions are fixed because the scan chain loads them.
    typedef struct packed {
        logic                       last;
        diag_op_t [OPS_MAX-1:0]     ops;
        logic                       bg;
        logic                       dir;
        logic [1:0]                 nops_m1;
    } diag_cmd_t;

    localparam int CMD_W = $bits(diag_cmd_t);

    typedef enum logic [2:0] {
        GS_IDLE,
        GS_INIT,
        GS_ISSUE,
        GS_CHECK,
        GS_WAIT,
        GS_DONE
    } gen_state_t;

endpackage

// File: rtl/sram_diag_cmd_store.sv
// Command store: a fixed March set, plus a serial chain that holds NCMD
// scanned commands. The index from the generator picks one slot from the
// source chosen by use_scan.
// Assumes shift_en stays low while a run is in progress (the top gates it).
module sram_diag_cmd_store
    import sram_diag_pkg::*;
#(
    parameter  int NCMD  = 4,
    localparam int IDX_W = (NCMD > 1) ? $clog2(NCMD) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_in,
    input  logic             use_scan,
    input  logic [IDX_W-1:0] idx,
    output diag_cmd_t        cmd
);

    localparam int CHAIN_W = NCMD * CMD_W;

    logic [CHAIN_W-1:0] chain;
    diag_cmd_t          rom_slot  [NCMD];
    diag_cmd_t          scan_slot [NCMD];

    // Built-in set: up w0; up r0 w1; down r1 w0; up r0 (last).
    function automatic diag_cmd_t builtin_cmd(input int k);
        diag_cmd_t c;
        c = '0;
        case (k)
            0: begin
                c.ops[0] = '{inv: 1'b0, rd: 1'b0};
            end
            1: begin
                c.nops_m1 = 2'd1;
                c.ops[0]  = '{inv: 1'b0, rd: 1'b1};
                c.ops[1]  = '{inv: 1'b1, rd: 1'b0};
            end
            2: begin
                c.nops_m1 = 2'd1;
                c.dir     = 1'b1;
                c.ops[0]  = '{inv: 1'b1, rd: 1'b1};
                c.ops[1]  = '{inv: 1'b0, rd: 1'b0};
            end
            3: begin
                c.ops[0] = '{inv: 1'b0, rd: 1'b1};
                c.last   = 1'b1;
            end
            default: begin
                c.last = 1'b1;
            end
        endcase
        return c;
    endfunction

    // Serial command chain, new bits enter at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (shift_en) begin
            chain <= {chain[CHAIN_W-2:0], shift_in};
        end
    end

    generate
        for (genvar k = 0; k < NCMD; k++) begin : g_slot
            assign rom_slot[k]  = builtin_cmd(k);
            assign scan_slot[k] = chain[k*CMD_W +: CMD_W];
        end
    endgenerate

    // Pick the current command from the selected source.
    assign cmd = use_scan ? scan_slot[idx] : rom_slot[idx];

endmodule

// File: rtl/sram_diag_pattern_gen.sv
// Pattern generator: walks commands, addresses and sessions. For each
// session it drives write or read enable from a session-indexed timing
// table, checks read data one cycle later, and on a mismatch waits for
// the fault-site indicator's continue pulse before resuming.
// Assumes a synchronous SRAM with one cycle of read latency.
module sram_diag_pattern_gen
    import sram_diag_pkg::*;
#(
    parameter  int AW    = 4,
    parameter  int DW    = 8,
    parameter  int NCMD  = 4,
    localparam int IDX_W = (NCMD > 1) ? $clog2(NCMD) : 1,
    localparam int REC_W = AW + 2 + DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  diag_cmd_t        cmd,
    input  logic             cont,
    input  logic [DW-1:0]    rdata,
    output logic [IDX_W-1:0] cidx,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    wdata,
    output logic             we,
    output logic             oe,
    output logic             err_load,
    output logic [REC_W-1:0] err_rec,
    output logic             running,
    output logic             clr,
    output logic             done
);

    gen_state_t       st, st_n;
    logic [1:0]       sess, sess_n;
    logic [AW-1:0]    acnt, acnt_n;
    logic [IDX_W-1:0] cidx_n;
    logic [1:0]       tim [OPS_MAX];
    diag_op_t         op;
    logic [DW-1:0]    pat;
    logic [DW-1:0]    expd;
    logic             mism;
    logic             step;
    logic             last_cmd;

    // Timing table: {we, oe} for each session slot of the current command.
    generate
        for (genvar s = 0; s < OPS_MAX; s++) begin : g_tim
            assign tim[s] = cmd.ops[s].rd ? 2'b01 : 2'b10;
        end
    endgenerate

    // Operation data and address for the current session.
    assign op       = cmd.ops[sess];
    assign pat      = cmd.bg ? {(DW/2){2'b01}} : '0;
    assign expd     = pat ^ {DW{op.inv}};
    assign addr     = cmd.dir ? ~acnt : acnt;
    assign wdata    = expd;
    assign we       = (st == GS_ISSUE) && tim[sess][1];
    assign oe       = (st == GS_ISSUE) && tim[sess][0];
    assign mism     = (st == GS_CHECK) && (rdata != expd);
    assign err_load = mism;
    assign err_rec  = {addr, sess, rdata};
    assign running  = (st == GS_INIT) || (st == GS_ISSUE) ||
                      (st == GS_CHECK) || (st == GS_WAIT);
    assign clr      = (st == GS_INIT);
    assign done     = (st == GS_DONE);
    assign last_cmd = cmd.last || (cidx == IDX_W'(NCMD - 1));
    assign step     = ((st == GS_ISSUE) && !op.rd) ||
                      ((st == GS_CHECK) && !mism) ||
                      ((st == GS_WAIT) && cont);

    // Next-state and counter update logic.
    always_comb begin
        st_n   = st;
        sess_n = sess;
        acnt_n = acnt;
        cidx_n = cidx;
        case (st)
            GS_IDLE, GS_DONE: if (start) st_n = GS_INIT;
            GS_INIT: begin
                sess_n = '0;
                acnt_n = '0;
                cidx_n = '0;
                st_n   = GS_ISSUE;
            end
            GS_ISSUE: if (op.rd) st_n = GS_CHECK;
            GS_CHECK: if (mism) st_n = GS_WAIT;
            default: ;
        endcase
        if (step) begin
            st_n = GS_ISSUE;
            if (sess != cmd.nops_m1) begin
                sess_n = sess + 2'd1;
            end else begin
                sess_n = '0;
                if (acnt != '1) begin
                    acnt_n = acnt + 1'b1;
                end else begin
                    acnt_n = '0;
                    if (last_cmd) st_n = GS_DONE;
                    else          cidx_n = cidx + 1'b1;
                end
            end
        end
        if (!en) st_n = GS_IDLE;
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= GS_IDLE;
            sess <= '0;
            acnt <= '0;
            cidx <= '0;
        end else begin
            st   <= st_n;
            sess <= sess_n;
            acnt <= acnt_n;
            cidx <= cidx_n;
        end
    end

    assert_we_oe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && oe));

    assert_wait_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_WAIT && !cont && en) |=> ($stable(acnt) && $stable(sess) && $stable(cidx)));

    assert_sess_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we || oe) |-> (sess <= cmd.nops_m1));

    assert_init_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_INIT && en) |=> (sess == '0 && acnt == '0 && cidx == '0));

    assert_done_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en && !start) |=> done);

endmodule

// File: rtl/sram_diag_fault_site.sv
// Fault-site indicator: captures an error record, sets a sticky flag,
// shifts the record out MSB first, then pulses continue for one cycle.
// Assumes a new load never arrives while a record is still shifting.
module sram_diag_fault_site #(
    parameter  int REC_W = 14,
    localparam int CNT_W = $clog2(REC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [REC_W-1:0] rec,
    output logic             sout,
    output logic             sout_vld,
    output logic             cont,
    output logic             flag
);

    logic [REC_W-1:0] sh;
    logic [CNT_W-1:0] cnt;

    // Capture, shift and flag handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            cnt  <= '0;
            cont <= 1'b0;
            flag <= 1'b0;
        end else begin
            cont <= 1'b0;
            if (clr) flag <= 1'b0;
            if (load) begin
                sh   <= rec;
                cnt  <= CNT_W'(REC_W);
                flag <= 1'b1;
            end else if (cnt != '0) begin
                sh  <= sh << 1;
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) cont <= 1'b1;
            end
        end
    end

    assign sout     = sh[REC_W-1];
    assign sout_vld = (cnt != '0);

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr));

    assert_cont_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cont |=> !cont);

endmodule

// File: rtl/sram_diag_top.sv
// Top of the SRAM diagnosis engine: the command store, the pattern generator
// and the fault-site indicator, plus the port multiplexer that hands the
// SRAM to either the system or the engine.
// Assumes the SRAM shares clk and returns read data one cycle after oe.
module sram_diag_top
    import sram_diag_pkg::*;
#(
    parameter  int AW    = 4,
    parameter  int DW    = 8,
    parameter  int NCMD  = 4,
    localparam int IDX_W = (NCMD > 1) ? $clog2(NCMD) : 1,
    localparam int REC_W = AW + 2 + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          diag_sel,
    input  logic          cmd_src,
    input  logic          start,
    input  logic          scan_en,
    input  logic          scan_in,
    input  logic [AW-1:0] sys_addr,
    input  logic [DW-1:0] sys_wdata,
    input  logic          sys_we,
    input  logic          sys_oe,
    output logic [DW-1:0] sys_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_oe,
    input  logic [DW-1:0] mem_rdata,
    output logic          err_sout,
    output logic          err_sout_vld,
    output logic          err_flag,
    output logic          done
);

    diag_cmd_t        cmd;
    logic [IDX_W-1:0] cidx;
    logic [AW-1:0]    g_addr;
    logic [DW-1:0]    g_wdata;
    logic             g_we;
    logic             g_oe;
    logic             err_load;
    logic [REC_W-1:0] err_rec;
    logic             running;
    logic             clr;
    logic             cont;

    sram_diag_cmd_store #(.NCMD(NCMD)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (scan_en && !running),
        .shift_in (scan_in),
        .use_scan (cmd_src),
        .idx      (cidx),
        .cmd      (cmd)
    );

    sram_diag_pattern_gen #(.AW(AW), .DW(DW), .NCMD(NCMD)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (diag_sel),
        .start    (start),
        .cmd      (cmd),
        .cont     (cont),
        .rdata    (mem_rdata),
        .cidx     (cidx),
        .addr     (g_addr),
        .wdata    (g_wdata),
        .we       (g_we),
        .oe       (g_oe),
        .err_load (err_load),
        .err_rec  (err_rec),
        .running  (running),
        .clr      (clr),
        .done     (done)
    );

    sram_diag_fault_site #(.REC_W(REC_W)) u_fsi (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load     (err_load),
        .rec      (err_rec),
        .sout     (err_sout),
        .sout_vld (err_sout_vld),
        .cont     (cont),
        .flag     (err_flag)
    );

    // SRAM port multiplexer between system access and the engine.
    assign mem_addr  = diag_sel ? g_addr  : sys_addr;
    assign mem_wdata = diag_sel ? g_wdata : sys_wdata;
    assign mem_we    = diag_sel ? g_we    : sys_we;
    assign mem_oe    = diag_sel ? g_oe    : sys_oe;
    assign sys_rdata = diag_sel ? '0      : mem_rdata;

    assert_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_sel && !running) |-> (!mem_we && !mem_oe));

    assert_report_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_load |=> (err_sout_vld && err_flag));

endmodule

// File: tb/sram_diag_top_test.sv
`timescale 1ns/1ps
module sram_diag_top_test;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int NCMD  = 4;
    localparam int REC_W = AW + 2 + DW;
    localparam int CW    = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          diag_sel = 1'b0, cmd_src = 1'b0, start = 1'b0;
    logic          scan_en = 1'b0, scan_in = 1'b0;
    logic [AW-1:0] sys_addr = '0;
    logic [DW-1:0] sys_wdata = '0;
    logic          sys_we = 1'b0, sys_oe = 1'b0;
    logic [DW-1:0] sys_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we, mem_oe;
    logic [DW-1:0] mem_rdata = '0;
    logic          err_sout, err_sout_vld, err_flag, done;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0]    sram     [1<<AW];
    logic [DW-1:0]    or_mask  [1<<AW];
    logic [DW-1:0]    and_mask [1<<AW];
    logic [REC_W-1:0] recs [8];
    int               nrec;

    always #2 clk = ~clk;

    sram_diag_top #(.AW(AW), .DW(DW), .NCMD(NCMD)) uut (
        .clk(clk), .rst_n(rst_n), .diag_sel(diag_sel), .cmd_src(cmd_src),
        .start(start), .scan_en(scan_en), .scan_in(scan_in),
        .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_we(sys_we),
        .sys_oe(sys_oe), .sys_rdata(sys_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_oe(mem_oe),
        .mem_rdata(mem_rdata), .err_sout(err_sout),
        .err_sout_vld(err_sout_vld), .err_flag(err_flag), .done(done)
    );

    // SRAM model with per-address stuck-at masks and one cycle read latency.
    always @(posedge clk) begin
        if (mem_we) sram[mem_addr] <= (mem_wdata | or_mask[mem_addr]) & ~and_mask[mem_addr];
        if (mem_oe) mem_rdata <= sram[mem_addr];
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_faults();
        for (int i = 0; i < (1<<AW); i++) begin
            or_mask[i]  = '0;
            and_mask[i] = '0;
        end
    endtask

    task automatic sys_write(input int a, input int d);
        @(negedge clk);
        sys_addr = AW'(a); sys_wdata = DW'(d); sys_we = 1'b1;
        @(negedge clk);
        sys_we = 1'b0;
    endtask

    task automatic sys_read(input int a, output int d);
        @(negedge clk);
        sys_addr = AW'(a); sys_oe = 1'b1;
        @(negedge clk);
        sys_oe = 1'b0;
        d = int'(sys_rdata);
    endtask

    // Pulse start and collect serial records until done; returns cycle count.
    task automatic run_engine(output int cyc);
        logic [REC_W-1:0] sh;
        int bc;
        nrec = 0; bc = 0; sh = '0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            if (err_sout_vld) begin
                sh = {sh[REC_W-2:0], err_sout};
                bc++;
                if (bc == REC_W) begin
                    if (nrec < 8) recs[nrec] = sh;
                    nrec++;
                    bc = 0;
                end
            end
            cyc++;
            @(negedge clk);
        end
        check("R12 done reached", int'(done), 1);
    endtask

    function automatic logic [CW-1:0] mk_cmd(input logic last, input logic [7:0] ops,
                                              input logic bg, input logic dir, input logic [1:0] nm1);
        return {last, ops, bg, dir, nm1};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R12 reset done low", int'(done), 0);
        check("R11 reset flag low", int'(err_flag), 0);
        check("R9 reset record idle", int'(err_sout_vld), 0);
        check("R2 reset we low", int'(mem_we), 0);
    endtask

    task automatic t_normal();
        int d;
        @(negedge clk);
        sys_addr = 4'h2; sys_wdata = 8'h3C; sys_we = 1'b1;
        #0.5;
        check("R1 addr passes", int'(mem_addr), 2);
        check("R1 we passes", int'(mem_we), 1);
        check("R1 wdata passes", int'(mem_wdata), 'h3C);
        @(negedge clk); sys_we = 1'b0;
        sys_read(2, d);
        check("R1 read back", d, 'h3C);
    endtask

    task automatic t_blocked();
        int d;
        diag_sel = 1'b1;
        @(negedge clk);
        sys_addr = 4'h2; sys_wdata = 8'h99; sys_we = 1'b1; sys_oe = 1'b1;
        #0.5;
        check("R2 we blocked", int'(mem_we), 0);
        check("R2 oe blocked", int'(mem_oe), 0);
        @(negedge clk); sys_we = 1'b0; sys_oe = 1'b0;
        check("R2 rdata zero", int'(sys_rdata), 0);
        diag_sel = 1'b0;
        sys_read(2, d);
        check("R2 word unchanged", d, 'h3C);
    endtask

    task automatic t_builtin_clean();
        int cyc, d;
        clear_faults();
        diag_sel = 1'b1; cmd_src = 1'b0;
        run_engine(cyc);
        check("R7 clean cycle count", cyc, 145);
        check("R4 no records", nrec, 0);
        check("R11 flag clear", int'(err_flag), 0);
        repeat (3) @(negedge clk);
        check("R12 done holds", int'(done), 1);
        diag_sel = 1'b0;
        sys_read(2, d);
        check("R4 final zeros", d, 0);
    endtask

    task automatic t_builtin_fault();
        int cyc, d;
        clear_faults();
        or_mask[5] = 8'h04;
        diag_sel = 1'b1; cmd_src = 1'b0;
        run_engine(cyc);
        check("R10 two records", nrec, 2);
        check("R9 first record", int'(recs[0]), int'({4'h5, 2'd0, 8'h04}));
        check("R4 second record", int'(recs[1]), int'({4'h5, 2'd0, 8'h04}));
        check("R11 flag held", int'(err_flag), 1);
        diag_sel = 1'b0;
        sys_read(5, d);
        check("R10 resumed writes", d, 'h04);
    endtask

    task automatic t_restart();
        int cyc;
        clear_faults();
        diag_sel = 1'b1; cmd_src = 1'b0;
        run_engine(cyc);
        check("R6 flag cleared by start", int'(err_flag), 0);
        check("R6 no records", nrec, 0);
        diag_sel = 1'b0;
    endtask

    task automatic t_scanned();
        logic [NCMD*CW-1:0] v;
        int cyc, d;
        clear_faults();
        or_mask[9]  = 8'h02;
        and_mask[3] = 8'h80;
        // slot0: up, bg 0x55, {write}; slot1: down, bg 0x55, {r, w~, r~}, last
        v = {13'h0, 13'h0,
             mk_cmd(1'b1, {2'b00, 2'b11, 2'b10, 2'b01}, 1'b1, 1'b1, 2'd2),
             mk_cmd(1'b0, 8'h00, 1'b1, 1'b0, 2'd0)};
        for (int i = NCMD*CW-1; i >= 0; i--) begin
            @(negedge clk); scan_en = 1'b1; scan_in = v[i];
        end
        @(negedge clk); scan_en = 1'b0;
        diag_sel = 1'b1; cmd_src = 1'b1;
        run_engine(cyc);
        check("R5 scanned records", nrec, 2);
        check("R8 down order first", int'(recs[0]), int'({4'h9, 2'd0, 8'h57}));
        check("R3 session two record", int'(recs[1]), int'({4'h3, 2'd2, 8'h2A}));
        diag_sel = 1'b0;
        sys_read(3, d);
        check("R3 inverted write", d, 'h2A);
        sys_read(0, d);
        check("R5 final word", d, 'hAA);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1<<AW); i++) sram[i] = '0;
        clear_faults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_normal();
        t_blocked();
        t_builtin_clean();
        t_builtin_fault();
        t_restart();
        t_scanned();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule